// File: doc/BRIEF.md
# Page Write Staging Buffer with Timed Commit

This block sits behind a two-wire serial memory slave and collects the data bytes of one write transfer into a page-sized staging buffer. The bus engine tells it when a write transfer names its start address, hands it each received data byte, and signals the end of the transfer. When a stop condition closes a transfer that carried at least one data byte, the block writes the staged bytes into the memory array. It then keeps a busy flag raised for a fixed, parameterised number of system clocks, which stands in for the self-timed nonvolatile write cycle.

Only the low page-offset bits of the running address advance, so a transfer longer than a page wraps around inside its own row and later bytes replace earlier ones. Each buffer slot has a valid flag. The commit writes only the slots that were filled, one per clock, starting from the lowest offset. While busy is high every input is ignored, and the bus engine uses the flag to withhold its address acknowledge, which supports acknowledge polling.

A transfer that ends with no data byte only loads the address, as in the dummy write that comes before a random read. A repeated start, or a new address load, throws away whatever is staged.

Top module: `pwb_page_stage`

## Requirements
- R1: While reset is asserted and after it is released, busy and mem_we are 0.
- R2: After addr_load with address A, the k-th accepted data byte (k from 0) is written to the address whose upper ADDR_W-PAGE_W bits equal those of A and whose low PAGE_W bits equal (A + k) mod 2^PAGE_W.
- R3: The row field (the upper ADDR_W-PAGE_W bits of mem_addr) never changes during one commit, including when the offset wraps from 2^PAGE_W-1 back to 0.
- R4: When more than 2^PAGE_W bytes arrive in one transfer, each offset is written at most once per commit, and it carries the last byte received for that offset.
- R5: A partial page is allowed. Only the offsets that received a byte are written, and no other array location is touched.
- R6: The commit writes in ascending offset order, one write per clock on consecutive clocks. The first write appears in the first cycle after the clock that sampled stop_evt.
- R7: stop_evt closing a transfer that holds staged data raises busy in the next cycle. busy then stays high for exactly WR_CYCLES cycles, and mem_we is asserted only while busy is high.
- R8: While busy is high, addr_load, byte_vld, start_evt and stop_evt are ignored. They produce no extra write, do not stretch busy, and leave no transfer open afterwards.
- R9: stop_evt closing a transfer with no data byte raises no busy and writes nothing.
- R10: start_evt before stop_evt discards the staged bytes, so a following stop_evt writes nothing. A second addr_load inside a transfer also discards the staged bytes and starts over at the new address.
- R11: When stop_evt and byte_vld are both high in the same cycle, stop_evt wins and the byte in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Opens a write transfer at addr_in and discards staged bytes |
| addr_in | input | ADDR_W | Start address of the write transfer |
| byte_vld | input | 1 | One received data byte is on byte_data |
| byte_data | input | DATA_W | Received data byte |
| start_evt | input | 1 | Repeated start seen on the bus; discards the transfer |
| stop_evt | input | 1 | Stop condition seen on the bus |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Write cycle in progress; the bus engine must not acknowledge |

## Verification
The hardest case to reach from the ports is a stale slot that survives into the next commit. That needs an overflowing transfer whose wrapped bytes overwrite filled slots, followed later by a partial page in another row. The bench runs a 20-byte transfer that starts near the end of a page, then a one-byte transfer in the last row. It also drives address loads, bytes, starts and stops on every cycle of a busy window. The scoreboard rejects any write it did not predict, so leftover flags and leaking inputs both show up as unexpected writes.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_COMMIT = 2'd2,
    ST_HOLD   = 2'd3
  } pwb_state_e;
endpackage

// File: rtl/pwb_slot_store.sv
module pwb_slot_store #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_all,
  input  logic                  wr_en,
  input  logic [PAGE_W-1:0]     wr_off,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  drop_en,
  input  logic [PAGE_W-1:0]     drop_off,
  input  logic [PAGE_W-1:0]     rd_off,
  output logic [DATA_W-1:0]     rd_data,
  output logic [(1<<PAGE_W)-1:0] flags
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit_wr, hit_drop, flag_d, data_en;

    always_comb begin
      hit_wr   = wr_en   && (wr_off   == PAGE_W'(s));
      hit_drop = drop_en && (drop_off == PAGE_W'(s));
      data_en  = hit_wr && !clr_all;
      if (clr_all)       flag_d = 1'b0;
      else if (hit_wr)   flag_d = 1'b1;
      else if (hit_drop) flag_d = 1'b0;
      else               flag_d = flags[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[s]  <= 1'b0;
        slot_q[s] <= '0;
      end else begin
        flags[s] <= flag_d;
        if (data_en) slot_q[s] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_off];
endmodule

// File: rtl/pwb_pick.sv
module pwb_pick #(
  parameter int IDX_W = 4
) (
  input  logic [(1<<IDX_W)-1:0] req,
  output logic                  any,
  output logic [IDX_W-1:0]      idx
);
  localparam int N = 1 << IDX_W;

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic last
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr || run;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = run && (cnt_q == LAST_V);
endmodule

// File: rtl/pwb_page_stage.sv
module pwb_page_stage
  import pwb_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;

  pwb_state_e        state_q, state_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [PAGE_W-1:0] off_q, off_d;
  logic              row_en, off_en;
  logic              clr_all, slot_wr, drop_en;
  logic [SLOTS-1:0]  flags;
  logic              pick_any;
  logic [PAGE_W-1:0] pick_idx;
  logic [DATA_W-1:0] rd_data;
  logic              tmr_clr, tmr_run, tmr_last;

  pwb_slot_store #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (clr_all),
    .wr_en    (slot_wr),
    .wr_off   (off_q),
    .wr_data  (byte_data),
    .drop_en  (drop_en),
    .drop_off (pick_idx),
    .rd_off   (pick_idx),
    .rd_data  (rd_data),
    .flags    (flags)
  );

  pwb_pick #(.IDX_W(PAGE_W)) u_pick (
    .req (flags),
    .any (pick_any),
    .idx (pick_idx)
  );

  pwb_timer #(.LIMIT(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .last  (tmr_last)
  );

  // Next-state process
  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    off_d   = off_q;
    row_en  = 1'b0;
    off_en  = 1'b0;
    clr_all = 1'b0;
    slot_wr = 1'b0;
    drop_en = 1'b0;
    tmr_clr = 1'b0;
    tmr_run = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (addr_load) begin
          state_d = ST_FILL;
          row_d   = addr_in[ADDR_W-1:PAGE_W];
          off_d   = addr_in[PAGE_W-1:0];
          row_en  = 1'b1;
          off_en  = 1'b1;
          clr_all = 1'b1;
        end
      end
      ST_FILL: begin
        if (addr_load) begin
          row_d   = addr_in[ADDR_W-1:PAGE_W];
          off_d   = addr_in[PAGE_W-1:0];
          row_en  = 1'b1;
          off_en  = 1'b1;
          clr_all = 1'b1;
        end else if (start_evt) begin
          state_d = ST_IDLE;
          clr_all = 1'b1;
        end else if (stop_evt) begin
          if (pick_any) begin
            state_d = ST_COMMIT;
            tmr_clr = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (byte_vld) begin
          slot_wr = 1'b1;
          off_d   = off_q + 1'b1;
          off_en  = 1'b1;
        end
      end
      ST_COMMIT: begin
        tmr_run = 1'b1;
        drop_en = pick_any;
        if (tmr_last) begin
          state_d = ST_IDLE;
          clr_all = 1'b1;
        end else if (!pick_any) begin
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        tmr_run = 1'b1;
        if (tmr_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      if (row_en) row_q <= row_d;
      if (off_en) off_q <= off_d;
    end
  end

  assign busy      = (state_q == ST_COMMIT) || (state_q == ST_HOLD);
  assign mem_we    = (state_q == ST_COMMIT) && pick_any;
  assign mem_addr  = {row_q, pick_idx};
  assign mem_wdata = rd_data;
endmodule

// File: rtl/pwb_page_stage_chk.sv
module pwb_page_stage_chk #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_evt,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy
);
  logic [31:0] blen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen_q <= '0;
    else if (busy) blen_q <= blen_q + 32'd1;
    else           blen_q <= '0;
  end

  // R7
  we_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R7
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (blen_q < 32'(WR_CYCLES)));

  // R7
  busy_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(blen_q) == 32'(WR_CYCLES - 1)));

  // R3
  row_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> $stable(mem_addr[ADDR_W-1:PAGE_W]));

  // R6
  offset_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[PAGE_W-1:0] > $past(mem_addr[PAGE_W-1:0])));
endmodule

bind pwb_page_stage pwb_page_stage_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt),
  .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy)
);

// File: tb/sim_pwb_page_stage.sv
`timescale 1ns/1ps
module sim_pwb_page_stage;
  localparam int AW = 11;
  localparam int PW = 4;
  localparam int DW = 8;
  localparam int WR = 40;
  localparam int SL = 1 << PW;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          addr_load, byte_vld, start_evt, stop_evt;
  logic [AW-1:0] addr_in;
  logic [DW-1:0] byte_data;
  logic          mem_we, busy;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  item_t         exp_q[$];
  logic [DW-1:0] m_data [SL];
  bit            m_flag [SL];
  int            m_row, m_off;
  bit            m_open;

  always #2.5 clk = ~clk;

  pwb_page_stage #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .WR_CYCLES(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_data(byte_data), .start_evt(start_evt),
    .stop_evt(stop_evt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every array write
  always @(negedge clk) begin
    if (rst_n === 1'b1 && mem_we === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R8", "unexpected write addr", int'(mem_addr), 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(mem_addr == e.a, "R2/R3", "write address", int'(mem_addr), int'(e.a));
        chk(mem_wdata == e.d, "R4", "write data", int'(mem_wdata), int'(e.d));
      end
    end
  end

  task automatic idle_inputs();
    addr_load = 0; byte_vld = 0; start_evt = 0; stop_evt = 0;
    addr_in = '0; byte_data = '0;
  endtask

  task automatic t_load(int a);
    addr_load = 1; addr_in = AW'(a);
    @(negedge clk);
    addr_load = 0;
    m_row = a >> PW; m_off = a & (SL - 1); m_open = 1;
    for (int i = 0; i < SL; i++) m_flag[i] = 0;
  endtask

  task automatic t_byte(int d);
    byte_vld = 1; byte_data = DW'(d);
    @(negedge clk);
    byte_vld = 0;
    if (m_open) begin
      m_data[m_off] = DW'(d); m_flag[m_off] = 1;
      m_off = (m_off + 1) & (SL - 1);
    end
  endtask

  task automatic t_start();
    start_evt = 1;
    @(negedge clk);
    start_evt = 0;
    m_open = 0;
    for (int i = 0; i < SL; i++) m_flag[i] = 0;
  endtask

  // Stop with optional noise while busy; optional byte in same cycle (R11)
  task automatic t_stop(string req, bit noisy, bit with_byte);
    bit want;
    int n;
    want = 0;
    if (m_open) begin
      for (int i = 0; i < SL; i++) begin
        if (m_flag[i]) begin
          item_t it;
          it.a = AW'((m_row << PW) | i);
          it.d = m_data[i];
          exp_q.push_back(it);
          want = 1;
        end
      end
    end
    m_open = 0;
    stop_evt = 1;
    if (with_byte) begin byte_vld = 1; byte_data = 8'hEE; end
    @(negedge clk);
    stop_evt = 0; byte_vld = 0;
    chk(busy == want, req, "busy after stop", int'(busy), int'(want));
    chk(mem_we == want, "R6", "first write right after stop", int'(mem_we), int'(want));
    n = 0;
    while (busy === 1'b1 && n < 10 * WR) begin
      n++;
      if (noisy) begin
        addr_load = n[0]; addr_in = AW'(n * 37);
        byte_vld = 1; byte_data = DW'(n);
        start_evt = n[1]; stop_evt = n[2];
      end
      @(negedge clk);
      idle_inputs();
    end
    chk(n == (want ? WR : 0), "R7", "busy length", n, want ? WR : 0);
    chk(exp_q.size() == 0, "R5", "writes still missing", exp_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    m_open = 0; m_row = 0; m_off = 0;
    for (int i = 0; i < SL; i++) begin m_flag[i] = 0; m_data[i] = '0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_we == 0, "R1", "outputs in reset", int'({busy, mem_we}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && mem_we == 0, "R1", "outputs after reset", int'({busy, mem_we}), 0);

    // R2: three bytes from mid-page offset
    t_load(11'h123);
    t_byte(8'hA1); t_byte(8'hA2); t_byte(8'hA3);
    t_stop("R2", 0, 0);

    // R3/R4: 20 bytes starting at offset E wrap and overwrite
    t_load(11'h05E);
    for (int k = 0; k < 20; k++) t_byte(8'h40 + k);
    t_stop("R4", 0, 0);

    // R5: a single byte in the last row; no stale slot may follow
    t_load(11'h7F9);
    t_byte(8'h5C);
    t_stop("R5", 0, 0);

    // R8: noise through the whole busy window, then a stop must do nothing
    t_load(11'h200);
    t_byte(8'h11); t_byte(8'h22);
    t_stop("R8", 1, 0);
    t_stop("R8", 0, 0);

    // R9: dummy write, address only
    t_load(11'h0A0);
    t_stop("R9", 0, 0);

    // R10: repeated start discards
    t_load(11'h310);
    t_byte(8'h77); t_byte(8'h78);
    t_start();
    t_stop("R10", 0, 0);

    // R10: second address load discards and restarts
    t_load(11'h400);
    t_byte(8'h90); t_byte(8'h91);
    t_load(11'h4F7);
    t_byte(8'h92);
    t_stop("R10", 0, 0);

    // R11: byte in the stop cycle is dropped
    t_load(11'h533);
    t_byte(8'hC3);
    t_stop("R11", 0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule